// File: doc/BRIEF.md
# Interrupt Pin to Message Write Translator

This block is a small I/O interrupt controller. It watches a vector of interrupt input pins and turns each firing input into one memory write message on an output channel. Every input owns one table entry. The entry holds the message address and the message data that go out when that input fires. It also holds a mask, a trigger mode (edge or level) and a polarity. Software reaches the table through an index register and a data window on a small register bus. The upper bits of the bus address select the block.

A second register in the same window lets another agent fire an input without any wire. A 32-bit write of an input number to the pin assertion register marks that input as asserted. This is a virtual pin. There is only an "assert now" command and no deassert. The block therefore always treats a virtual assertion as level-triggered. It sets the entry's remote-pending flag when the message leaves, and it sends nothing more for that input until an end-of-interrupt write clears the flag. The end-of-interrupt write carries the entry's data value. Messages leave one at a time on a valid/ready channel, and the lowest-numbered ready input goes first.

Top module: `pin_msg_xlate`

## Requirements
- R1: After reset, `msg_valid` is low, `bus_rdata` is zero, and every table entry reads back as masked with all other fields zero.
- R2: A write to offset 0x00 loads the index register. Index 2*i selects word 0 of entry i and index 2*i+1 selects word 1. Reads and writes at offset 0x10 reach the selected word. Word 0 holds the message data in bits 15:0, mask in bit 16, level mode in bit 17, active-low polarity in bit 18 and remote-pending in bit 19. Word 1 holds the 32-bit message address. Read data appears on `bus_rdata` one clock after the read strobe.
- R3: An unmasked edge-mode input sends exactly one message for each inactive-to-active transition of its pin. The active level is high, or low when bit 18 is set. Holding the pin active sends nothing further.
- R4: An unmasked level-mode input whose pin is active sends a message and sets its remote-pending flag. If the pin is still active once the flag is cleared, it sends again.
- R5: A write at offset 0x20 with a value below 24 fires that input as a virtual pin. The message uses the entry's address and data. Remote-pending is set even when the entry is in edge mode, and a repeated virtual write sends nothing until the flag is cleared.
- R6: A write at offset 0x20 with a value of 24 or more sends no message and changes no state.
- R7: A masked input sends no message, but its pending assertion is kept and is sent once the mask is cleared.
- R8: An end-of-interrupt write clears remote-pending in every entry whose data field equals `eoi_data`. A write with a non-matching value has no effect.
- R9: When several inputs are ready, the lowest-numbered one is sent first. `msg_valid`, `msg_addr` and `msg_data` stay steady until `msg_ready` is seen.
- R10: Remote-pending reads back in word 0 bit 19 and cannot be changed by a window write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 24 | Physical interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 32 | Register byte address (upper 24 bits select the block) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, one clock after the strobe |
| eoi_valid | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 16 | Data value carried by the end-of-interrupt write |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data, zero-extended from 16 bits |

## Verification
The hardest situation to reach is a set of inputs that are all ready at once while the message slot is already occupied. Only in that state does the lowest-first rule become visible. The stimulus holds `msg_ready` low and fires one virtual pin to fill the slot. It then fires two lower-numbered virtual pins behind it, and the bench expects the remaining order to be lowest first once `msg_ready` rises. A second hard corner is a level input whose pin stays active across an end-of-interrupt. The bench first sends a non-matching end-of-interrupt value to show the flag survives, then sends the matching value and expects a second message.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 32;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mask;
        logic              lvl;
        logic              pol_low;
        logic              remote;
        logic [ADDR_W-1:0] addr;
    } ent_t;

    function automatic logic [31:0] ent_word0(ent_t e);
        return {12'd0, e.remote, e.pol_low, e.lvl, e.mask, e.data};
    endfunction
endpackage

// File: rtl/pmx_pin_sense.sv
module pmx_pin_sense #(
    parameter int N_IN = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] pin_i,
    input  logic [N_IN-1:0] pol_low,
    output logic [N_IN-1:0] act,
    output logic [N_IN-1:0] rise
);
    typedef struct packed {
        logic [N_IN-1:0] pin_s;
        logic [N_IN-1:0] act_prev;
    } sense_t;

    sense_t s_d, s_q;

    for (genvar g = 0; g < N_IN; g++) begin : g_bit
        assign act[g]  = s_q.pin_s[g] ^ pol_low[g];
        assign rise[g] = act[g] & ~s_q.act_prev[g];
    end

    always_comb begin
        s_d          = s_q;
        s_d.pin_s    = pin_i;
        s_d.act_prev = act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pmx_prio.sv
module pmx_prio #(
    parameter int N_IN = 24,
    localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic [N_IN-1:0] req,
    output logic            gnt_valid,
    output logic [IW-1:0]   gnt_idx
);
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pin_msg_xlate.sv
module pin_msg_xlate
    import pmx_pkg::*;
#(
    parameter int          N_IN = 24,
    parameter logic [31:0] BASE = 32'hFEC0_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] pin_i,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [31:0]     bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic            eoi_valid,
    input  logic [15:0]     eoi_data,
    output logic            msg_valid,
    input  logic            msg_ready,
    output logic [31:0]     msg_addr,
    output logic [31:0]     msg_data
);
    localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam logic [7:0] OFF_IDX = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [7:0] OFF_PAR = 8'h20;

    typedef struct packed {
        ent_t [N_IN-1:0]   ent;
        logic [N_IN-1:0]   epend;
        logic [N_IN-1:0]   vpend;
        logic [7:0]        widx;
        logic [31:0]       rdata;
        logic              mvalid;
        logic [IW-1:0]     midx;
        logic [31:0]       maddr;
        logic [DATA_W-1:0] mdata;
    } st_t;

    function automatic st_t rst_state();
        st_t r;
        r = '0;
        for (int i = 0; i < N_IN; i++) r.ent[i].mask = 1'b1;
        return r;
    endfunction

    st_t st_d, st_q;

    logic [N_IN-1:0] pol_vec, lvl_vec, mask_vec, remote_vec;
    logic [N_IN-1:0] act, rise, new_edge, req_vec;
    logic            gnt_valid;
    logic [IW-1:0]   gnt_idx;
    logic [IW-1:0]   msg_idx;

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            pol_vec[i]    = st_q.ent[i].pol_low;
            lvl_vec[i]    = st_q.ent[i].lvl;
            mask_vec[i]   = st_q.ent[i].mask;
            remote_vec[i] = st_q.ent[i].remote;
        end
    end

    pmx_pin_sense #(.N_IN(N_IN)) u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .pol_low (pol_vec),
        .act     (act),
        .rise    (rise)
    );

    assign new_edge = rise & ~lvl_vec;
    assign req_vec  = ~mask_vec & ~remote_vec &
                      (st_q.epend | new_edge | st_q.vpend | (lvl_vec & act));

    pmx_prio #(.N_IN(N_IN)) u_prio (
        .req       (req_vec),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    logic       hit;
    logic [7:0] off;
    logic       win_ok;
    logic [6:0] win_ent;
    assign hit     = (bus_addr[31:8] == BASE[31:8]);
    assign off     = bus_addr[7:0];
    assign win_ent = st_q.widx[7:1];
    assign win_ok  = (32'(win_ent) < 32'(N_IN));

    always_comb begin
        st_d = st_q;

        // pending edges are latched every cycle; the grant below may consume them
        st_d.epend = st_q.epend | new_edge;

        for (int i = 0; i < N_IN; i++) begin
            if (eoi_valid && st_q.ent[i].remote && st_q.ent[i].data == eoi_data)
                st_d.ent[i].remote = 1'b0;
        end

        if (st_q.mvalid) begin
            if (msg_ready) st_d.mvalid = 1'b0;
        end else if (gnt_valid) begin
            st_d.mvalid          = 1'b1;
            st_d.midx            = gnt_idx;
            st_d.maddr           = st_q.ent[gnt_idx].addr;
            st_d.mdata           = st_q.ent[gnt_idx].data;
            st_d.epend[gnt_idx]  = 1'b0;
            st_d.vpend[gnt_idx]  = 1'b0;
            if (st_q.ent[gnt_idx].lvl || st_q.vpend[gnt_idx])
                st_d.ent[gnt_idx].remote = 1'b1;
        end

        if (bus_wr && hit) begin
            if (off == OFF_PAR && bus_wdata < 32'(N_IN))
                st_d.vpend[bus_wdata[IW-1:0]] = 1'b1;
            if (off == OFF_IDX)
                st_d.widx = bus_wdata[7:0];
            if (off == OFF_WIN && win_ok) begin
                if (st_q.widx[0]) begin
                    st_d.ent[win_ent].addr = bus_wdata;
                end else begin
                    st_d.ent[win_ent].data    = bus_wdata[15:0];
                    st_d.ent[win_ent].mask    = bus_wdata[16];
                    st_d.ent[win_ent].lvl     = bus_wdata[17];
                    st_d.ent[win_ent].pol_low = bus_wdata[18];
                end
            end
        end

        if (bus_rd && hit) begin
            st_d.rdata = '0;
            if (off == OFF_IDX) st_d.rdata = {24'd0, st_q.widx};
            if (off == OFF_WIN && win_ok)
                st_d.rdata = st_q.widx[0] ? st_q.ent[win_ent].addr
                                          : ent_word0(st_q.ent[win_ent]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= rst_state();
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign msg_valid = st_q.mvalid;
    assign msg_addr  = st_q.maddr;
    assign msg_data  = {16'd0, st_q.mdata};
    assign msg_idx   = st_q.midx;
endmodule

// File: rtl/pin_msg_xlate_chk.sv
module pin_msg_xlate_chk #(
    parameter int N_IN = 24,
    localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            msg_valid,
    input logic            msg_ready,
    input logic [31:0]     msg_addr,
    input logic [31:0]     msg_data,
    input logic [IW-1:0]   msg_idx,
    input logic [N_IN-1:0] mask_vec,
    input logic [N_IN-1:0] remote_vec,
    input logic [N_IN-1:0] req_vec
);
    logic [N_IN-1:0] mask_prev, remote_prev, req_prev;
    logic [N_IN-1:0] below;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_prev   <= '1;
            remote_prev <= '0;
            req_prev    <= '0;
        end else begin
            mask_prev   <= mask_vec;
            remote_prev <= remote_vec;
            req_prev    <= req_vec;
        end
    end

    always_comb begin
        for (int i = 0; i < N_IN; i++) below[i] = (i < int'(msg_idx));
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !msg_valid);

    p_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (req_prev & below) == '0);

    p_masked_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !mask_prev[msg_idx]);

    p_no_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !remote_prev[msg_idx]);
endmodule

bind pin_msg_xlate pin_msg_xlate_chk #(.N_IN(N_IN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data),
    .msg_idx    (msg_idx),
    .mask_vec   (mask_vec),
    .remote_vec (remote_vec),
    .req_vec    (req_vec)
);

// File: tb/tb_pin_msg_xlate.sv
`timescale 1ns/1ps
module tb_pin_msg_xlate;
    localparam int N = 24;
    localparam logic [31:0] BASE = 32'hFEC0_0000;

    logic clk = 0, rst_n = 0;
    logic [N-1:0] pin_i = '0;
    logic bus_wr = 0, bus_rd = 0, eoi_valid = 0, msg_ready = 1;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [15:0] eoi_data = '0;
    logic [31:0] bus_rdata, msg_addr, msg_data;
    logic msg_valid;

    always #2 clk = ~clk;

    pin_msg_xlate #(.N_IN(N), .BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eoi_valid(eoi_valid), .eoi_data(eoi_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] actual, input logic [31:0] expect_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, actual, expect_v);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] md [N];
    logic [31:0] ma [N];
    bit mmask [N], mlvl [N], mpol [N], mrem [N], mep [N], mvp [N];
    bit mpin [N], mprev [N];
    logic [7:0]  mwidx;
    logic [31:0] mrdata, mmaddr;
    logic [15:0] mmdata;
    bit          mvalid;

    function automatic logic [31:0] w0(int i);
        return {12'd0, mrem[i], mpol[i], mlvl[i], mmask[i], md[i]};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                md[i] = 0; ma[i] = 0; mmask[i] = 1; mlvl[i] = 0; mpol[i] = 0;
                mrem[i] = 0; mep[i] = 0; mvp[i] = 0; mpin[i] = 0; mprev[i] = 0;
            end
            mwidx = 0; mrdata = 0; mvalid = 0; mmaddr = 0; mmdata = 0;
        end else begin
            bit actv [N];
            bit edg [N];
            int g;
            int e;
            bit hit;
            hit = (bus_addr[31:8] == BASE[31:8]);
            e = int'(mwidx) / 2;
            if (bus_rd && hit) begin
                mrdata = 0;
                if (bus_addr[7:0] == 8'h00) mrdata = {24'd0, mwidx};
                if (bus_addr[7:0] == 8'h10 && e < N) mrdata = mwidx[0] ? ma[e] : w0(e);
            end
            g = -1;
            for (int i = 0; i < N; i++) begin
                actv[i] = mpin[i] ^ mpol[i];
                edg[i]  = actv[i] && !mprev[i] && !mlvl[i];
                if (g < 0 && !mmask[i] && !mrem[i] &&
                    (mep[i] || edg[i] || mvp[i] || (mlvl[i] && actv[i]))) g = i;
            end
            for (int i = 0; i < N; i++) begin
                mprev[i] = actv[i];
                mpin[i]  = pin_i[i];
                if (edg[i]) mep[i] = 1;
                if (eoi_valid && mrem[i] && md[i] == eoi_data) mrem[i] = 0;
            end
            if (mvalid) begin
                if (msg_ready) mvalid = 0;
            end else if (g >= 0) begin
                mvalid = 1; mmaddr = ma[g]; mmdata = md[g];
                if (mlvl[g] || mvp[g]) mrem[g] = 1;
                mep[g] = 0; mvp[g] = 0;
            end
            if (bus_wr && hit) begin
                if (bus_addr[7:0] == 8'h20 && bus_wdata < N) mvp[bus_wdata] = 1;
                if (bus_addr[7:0] == 8'h10 && e < N) begin
                    if (mwidx[0]) ma[e] = bus_wdata;
                    else begin
                        md[e] = bus_wdata[15:0]; mmask[e] = bus_wdata[16];
                        mlvl[e] = bus_wdata[17]; mpol[e] = bus_wdata[18];
                    end
                end
                if (bus_addr[7:0] == 8'h00) mwidx = bus_wdata[7:0];
            end
        end
    end

    // per-clock comparison against the model (R1, R3, R4, R5, R7, R9)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(msg_valid == mvalid, "R9", "model msg_valid", {31'd0, msg_valid}, {31'd0, mvalid});
            if (mvalid) begin
                chk(msg_addr == mmaddr, "R5", "model msg_addr", msg_addr, mmaddr);
                chk(msg_data == {16'd0, mmdata}, "R5", "model msg_data", msg_data, {16'd0, mmdata});
            end
            chk(bus_rdata == mrdata, "R2", "model bus_rdata", bus_rdata, mrdata);
        end
    end

    // delivered-message bookkeeping
    int cnt [N];
    int ord [$];
    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready && msg_data[7:0] < N) begin
            cnt[msg_data[7:0]]++;
            ord.push_back(int'(msg_data[7:0]));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = BASE | 32'(off); bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] off, output logic [31:0] v);
        @(negedge clk); bus_rd = 1; bus_addr = BASE | 32'(off);
        @(negedge clk); bus_rd = 0; v = bus_rdata;
    endtask

    task automatic rd_word(input int i, input int w, output logic [31:0] v);
        wr(8'h00, 32'(2 * i + w));
        rd(8'h10, v);
    endtask

    task automatic prog(input int i, input bit msk, input bit lvl, input bit pol);
        wr(8'h00, 32'(2 * i + 1));
        wr(8'h10, 32'hFEE0_0000 + 32'(i * 16));
        wr(8'h00, 32'(2 * i));
        wr(8'h10, {13'd0, pol, lvl, msk, 16'h0100 + 16'(i)});
    endtask

    task automatic eoi(input logic [15:0] d);
        @(negedge clk); eoi_valid = 1; eoi_data = d;
        @(negedge clk); eoi_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int total();
        int t = 0;
        foreach (cnt[i]) t += cnt[i];
        return t;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int t0;
        foreach (cnt[i]) cnt[i] = 0;
        idle(5);
        rst_n = 1;
        idle(2);

        // R1: reset state
        chk(msg_valid == 0, "R1", "msg_valid after reset", {31'd0, msg_valid}, 0);
        chk(bus_rdata == 0, "R1", "rdata after reset", bus_rdata, 0);
        rd_word(5, 0, v);
        chk(v == 32'h0001_0000, "R1", "entry 5 word0 after reset", v, 32'h0001_0000);

        // R2: program all entries masked, read back
        for (int i = 0; i < N; i++) prog(i, 1, 0, 0);
        rd_word(7, 0, v);
        chk(v == 32'h0001_0107, "R2", "entry 7 word0", v, 32'h0001_0107);
        rd_word(7, 1, v);
        chk(v == 32'hFEE0_0070, "R2", "entry 7 word1", v, 32'hFEE0_0070);
        rd(8'h00, v);
        chk(v == 32'd15, "R2", "index register read", v, 32'd15);

        prog(3, 0, 0, 0);
        prog(4, 0, 1, 0);
        prog(6, 0, 0, 0);
        prog(12, 0, 0, 0);
        prog(20, 0, 0, 0);
        prog(9, 0, 1, 1);
        idle(8);
        chk(cnt[9] == 1, "R4", "active-low level input fires", 32'(cnt[9]), 1);

        // R3: edge input, two transitions
        pin_i[3] = 1; idle(3); pin_i[3] = 0; idle(3); pin_i[3] = 1; idle(8);
        chk(cnt[3] == 2, "R3", "edge count after two rises", 32'(cnt[3]), 2);
        idle(10);
        chk(cnt[3] == 2, "R3", "held-active edge sends nothing more", 32'(cnt[3]), 2);
        pin_i[3] = 0; idle(3);

        // R4 / R8 / R10: level input with remote-pending
        pin_i[4] = 1; idle(10);
        chk(cnt[4] == 1, "R4", "level input first message", 32'(cnt[4]), 1);
        rd_word(4, 0, v);
        chk(v[19] == 1, "R10", "remote bit visible", {31'd0, v[19]}, 1);
        wr(8'h10, 32'h0002_0104);
        rd(8'h10, v);
        chk(v[19] == 1, "R10", "remote bit not writable", {31'd0, v[19]}, 1);
        eoi(16'h01FF); idle(8);
        chk(cnt[4] == 1, "R8", "non-matching eoi ignored", 32'(cnt[4]), 1);
        rd(8'h10, v);
        chk(v[19] == 1, "R8", "remote kept after wrong eoi", {31'd0, v[19]}, 1);
        eoi(16'h0104); idle(8);
        chk(cnt[4] == 2, "R4", "resend after eoi while active", 32'(cnt[4]), 2);
        pin_i[4] = 0; idle(3);
        eoi(16'h0104); idle(8);
        chk(cnt[4] == 2, "R4", "no resend once inactive", 32'(cnt[4]), 2);
        rd(8'h10, v);
        chk(v[19] == 0, "R8", "matching eoi clears remote", {31'd0, v[19]}, 0);

        // R5: virtual pin on edge-mode entry 3
        wr(8'h20, 32'd3); idle(8);
        chk(cnt[3] == 3, "R5", "virtual pin message", 32'(cnt[3]), 3);
        rd_word(3, 0, v);
        chk(v[19] == 1, "R5", "virtual pin sets remote on edge entry", {31'd0, v[19]}, 1);
        wr(8'h20, 32'd3); idle(8);
        chk(cnt[3] == 3, "R5", "repeat virtual write held", 32'(cnt[3]), 3);
        eoi(16'h0103); idle(8);
        chk(cnt[3] == 4, "R5", "held virtual write sent after eoi", 32'(cnt[3]), 4);
        eoi(16'h0103); idle(3);

        // R6: out-of-range virtual pin values
        t0 = total();
        wr(8'h20, 32'd24);
        wr(8'h20, 32'hFFFF_FFFF);
        idle(10);
        chk(total() == t0, "R6", "out-of-range pin assert ignored", 32'(total()), 32'(t0));

        // R7: masked input keeps its pending assertion
        wr(8'h20, 32'd10); idle(20);
        chk(cnt[10] == 0, "R7", "masked input silent", 32'(cnt[10]), 0);
        prog(10, 0, 0, 0); idle(8);
        chk(cnt[10] == 1, "R7", "pending sent after unmask", 32'(cnt[10]), 1);

        // R9: lowest-first behind a stalled slot
        msg_ready = 0;
        wr(8'h20, 32'd20); idle(3);
        chk(msg_valid && msg_data == 32'h114, "R9", "slot holds input 20", msg_data, 32'h114);
        wr(8'h20, 32'd12);
        wr(8'h20, 32'd6);
        idle(5);
        chk(msg_data == 32'h114, "R9", "slot stable while stalled", msg_data, 32'h114);
        ord.delete();
        msg_ready = 1;
        idle(12);
        chk(ord.size() == 3, "R9", "three messages drained", 32'(ord.size()), 3);
        if (ord.size() == 3) begin
            chk(ord[0] == 20, "R9", "first is stalled 20", 32'(ord[0]), 20);
            chk(ord[1] == 6, "R9", "then lowest 6", 32'(ord[1]), 6);
            chk(ord[2] == 12, "R9", "then 12", 32'(ord[2]), 12);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule